// File: doc/BRIEF.md
# Time-Stamp Counter

This block keeps a 64-bit running count of time for a processor core. The count advances by one on each qualifying tick and is frozen only while the deep-sleep input is high. Halt and stop-clock states have no input here. The enclosing core keeps delivering ticks through them, so counting carries on. A configuration input selects the tick source:
- **Variable rate:** the count steps on every core-clock tick.
- **Constant rate:** the count steps on a fixed-rate reference tick, divided by a parameterised prescaler, so the step rate does not follow core frequency changes.

Software reaches the count in two ways.
- **Stamp read.** This is the read used by user code. A restrict flag gates it: when the flag is high, only privilege level 0 may read. A refused read returns nothing and raises a fault pulse.
- **Register port.** A single address on the register port reads all 64 bits or writes them. A write either loads all 64 bits or loads the low half and clears the high half, as chosen by a write-mode input.

Top module: `tsc_unit`

## Requirements
- R1: While reset is low the count is zero. `rd_valid_o` and `fault_o` are 0.
- R2: When `rate_const_i`=0 and `deep_sleep_i`=0, the count rises by exactly one on each clock edge where `core_tick_i`=1. `ref_tick_i` has no effect in this mode.
- R3: While `deep_sleep_i`=1 the count holds its value whatever the tick inputs do, and the reference prescaler does not advance. A register write still takes effect.
- R4: When `rate_const_i`=1, the count rises by one for every REF_DIV edges with `ref_tick_i`=1, counted since reset. `core_tick_i` has no effect in this mode.
- R5: A stamp read (`stamp_rd_i`=1) is granted when `tsd_i`=0 at any privilege, or when `priv_i`=0. The cycle after a granted read, `rd_valid_o`=1 and `rd_data_o` holds the count.
- R6: A stamp read with `tsd_i`=1 and `priv_i`≠0 is refused. The next cycle `fault_o`=1 for exactly one cycle, with `rd_valid_o`=0 and `rd_data_o`=0.
- R7: A register read (`reg_rd_i`=1) at address 0x010 returns all 64 bits the next cycle, whatever the privilege or restrict flag. Reads and writes at any other address return no valid data and leave the count unchanged.
- R8: A register write at 0x010 with `wr_full_i`=0 loads `reg_wdata_i[31:0]` into the low 32 bits and clears the high 32 bits.
- R9: A register write at 0x010 with `wr_full_i`=1 loads all 64 bits of `reg_wdata_i`.
- R10: A write in the same cycle as a tick wins. The written value is held, and counting resumes with the next tick.
- R11: The count wraps from all ones to zero.
- R12: A read in the same cycle as an increment returns the value from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| core_tick_i | input | 1 | Core-clock tick enable (variable rate) |
| ref_tick_i | input | 1 | Fixed-rate reference tick enable (constant rate) |
| rate_const_i | input | 1 | 1 selects constant rate, 0 selects variable rate |
| deep_sleep_i | input | 1 | Freezes the count while high |
| stamp_rd_i | input | 1 | Privilege-checked stamp read request |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | CNT_W | Register write data |
| wr_full_i | input | 1 | 1 writes all bits, 0 writes low LOW_W bits and clears the rest |
| priv_i | input | PRIV_W | Current privilege level, 0 is most privileged |
| tsd_i | input | 1 | Restricts stamp reads to privilege 0 when high |
| rd_data_o | output | CNT_W | Read data, zero when not valid |
| rd_valid_o | output | 1 | Read data valid |
| fault_o | output | 1 | Refused stamp read pulse |

## Verification
The bench builds the block with the default 64-bit count and 32-bit legacy write width, but sets REF_DIV to 3. This makes the divided reference path the one that is exercised. The bench can then check the carry-over of the prescaler phase across an uneven number of reference ticks, which a pass-through divider could not show. Full-width writes let the bench seed the count at all ones, so the wrap can be seen within a single tick.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   // Tick source selected by the rate input
   typedef enum logic {
      RATE_CORE = 1'b0,
      RATE_REF  = 1'b1
   } rate_e;

   // Write width selected by the write-mode input
   typedef enum logic {
      WR_LOW  = 1'b0,
      WR_WIDE = 1'b1
   } wr_mode_e;

   // Per-cycle access decision
   typedef struct packed {
      logic grant;   // read accepted, data returned next cycle
      logic deny;    // stamp read refused by privilege check
      logic load;    // write hits the counter address
   } access_s;

endpackage

// File: rtl/tsc_prescale.sv
module tsc_prescale #(
   parameter int unsigned DIV = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic live_i,
   output logic step_o
);
   localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= '0;
      end else if (live_i) begin
         phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
   end

   assign step_o = live_i && (phase_q == LAST);
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned LOW_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic             load_i,
   input  logic             wide_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] count_o
);
   localparam int unsigned HIGH_W = CNT_W - LOW_W;

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      if (wide_i) begin
         load_val = wdata_i;
      end else begin
         load_val = {{HIGH_W{1'b0}}, wdata_i[LOW_W-1:0]};
      end
   end

   // Load beats step; plain add wraps from all ones to zero
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (load_i) begin
         count_q <= load_val;
      end else if (step_i) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;
endmodule

// File: rtl/tsc_gate.sv
module tsc_gate
   import tsc_pkg::*;
#(
   parameter int unsigned            CNT_W      = 64,
   parameter int unsigned            ADDR_W     = 12,
   parameter int unsigned            PRIV_W     = 2,
   parameter logic [ADDR_W-1:0]      STAMP_ADDR = ADDR_W'('h010)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              stamp_rd_i,
   input  logic              reg_rd_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [PRIV_W-1:0] priv_i,
   input  logic              tsd_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              load_o,
   output logic [CNT_W-1:0]  rd_data_o,
   output logic              rd_valid_o,
   output logic              fault_o
);
   access_s acc;
   logic    addr_hit;
   logic    stamp_ok;

   assign addr_hit = (reg_addr_i == STAMP_ADDR);
   assign stamp_ok = !tsd_i || (priv_i == '0);

   always_comb begin
      acc.load  = reg_wr_i && addr_hit;
      acc.grant = (reg_rd_i && addr_hit) || (stamp_rd_i && stamp_ok);
      acc.deny  = stamp_rd_i && !stamp_ok;
   end

   assign load_o = acc.load;

   // Response register: data is the count seen before this edge's update
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_data_o  <= '0;
         rd_valid_o <= 1'b0;
         fault_o    <= 1'b0;
      end else begin
         rd_data_o  <= acc.grant ? count_i : '0;
         rd_valid_o <= acc.grant;
         fault_o    <= acc.deny;
      end
   end
endmodule

// File: rtl/tsc_unit.sv
module tsc_unit
   import tsc_pkg::*;
#(
   parameter int unsigned        CNT_W      = 64,
   parameter int unsigned        LOW_W      = 32,
   parameter int unsigned        ADDR_W     = 12,
   parameter int unsigned        PRIV_W     = 2,
   parameter logic [ADDR_W-1:0]  STAMP_ADDR = ADDR_W'('h010),
   parameter int unsigned        REF_DIV    = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              core_tick_i,
   input  logic              ref_tick_i,
   input  logic              rate_const_i,
   input  logic              deep_sleep_i,
   input  logic              stamp_rd_i,
   input  logic              reg_rd_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [CNT_W-1:0]  reg_wdata_i,
   input  logic              wr_full_i,
   input  logic [PRIV_W-1:0] priv_i,
   input  logic              tsd_i,
   output logic [CNT_W-1:0]  rd_data_o,
   output logic              rd_valid_o,
   output logic              fault_o
);
   // Elaboration-time parameter checks
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (LOW_W < 1 || LOW_W >= CNT_W) begin : g_bad_low
      $error("LOW_W must lie in 1..CNT_W-1");
   end
   if (REF_DIV < 1) begin : g_bad_div
      $error("REF_DIV must be at least 1");
   end
   if (PRIV_W < 1 || ADDR_W < 1) begin : g_bad_bus
      $error("PRIV_W and ADDR_W must be positive");
   end

   rate_e            rate;
   wr_mode_e         wmode;
   logic             ref_live;
   logic             ref_step;
   logic             core_step;
   logic             step;
   logic             load;
   logic [CNT_W-1:0] stamp_q;

   assign rate  = rate_e'(rate_const_i);
   assign wmode = wr_mode_e'(wr_full_i);

   // Reference path only moves when selected and awake
   assign ref_live  = ref_tick_i && !deep_sleep_i && (rate == RATE_REF);
   assign core_step = core_tick_i && !deep_sleep_i && (rate == RATE_CORE);

   if (REF_DIV == 1) begin : g_ref_direct
      assign ref_step = ref_live;
   end else begin : g_ref_div
      tsc_prescale #(
         .DIV (REF_DIV)
      ) i_prescale (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .live_i (ref_live),
         .step_o (ref_step)
      );
   end

   assign step = core_step || ref_step;

   tsc_counter #(
      .CNT_W (CNT_W),
      .LOW_W (LOW_W)
   ) i_counter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step),
      .load_i  (load),
      .wide_i  (wmode == WR_WIDE),
      .wdata_i (reg_wdata_i),
      .count_o (stamp_q)
   );

   tsc_gate #(
      .CNT_W      (CNT_W),
      .ADDR_W     (ADDR_W),
      .PRIV_W     (PRIV_W),
      .STAMP_ADDR (STAMP_ADDR)
   ) i_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stamp_rd_i (stamp_rd_i),
      .reg_rd_i   (reg_rd_i),
      .reg_wr_i   (reg_wr_i),
      .reg_addr_i (reg_addr_i),
      .priv_i     (priv_i),
      .tsd_i      (tsd_i),
      .count_i    (stamp_q),
      .load_o     (load),
      .rd_data_o  (rd_data_o),
      .rd_valid_o (rd_valid_o),
      .fault_o    (fault_o)
   );
endmodule

// File: rtl/tsc_unit_chk.sv
module tsc_unit_chk #(
   parameter int unsigned        CNT_W      = 64,
   parameter int unsigned        LOW_W      = 32,
   parameter int unsigned        ADDR_W     = 12,
   parameter int unsigned        PRIV_W     = 2,
   parameter logic [ADDR_W-1:0]  STAMP_ADDR = ADDR_W'('h010)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              core_tick_i,
   input logic              rate_const_i,
   input logic              deep_sleep_i,
   input logic              stamp_rd_i,
   input logic              reg_rd_i,
   input logic              reg_wr_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [CNT_W-1:0]  reg_wdata_i,
   input logic              wr_full_i,
   input logic [PRIV_W-1:0] priv_i,
   input logic              tsd_i,
   input logic [CNT_W-1:0]  rd_data_o,
   input logic              rd_valid_o,
   input logic              fault_o,
   input logic [CNT_W-1:0]  stamp_q
);
   logic wr_at;
   logic rd_at;
   assign wr_at = reg_wr_i && (reg_addr_i == STAMP_ADDR);
   assign rd_at = reg_rd_i && (reg_addr_i == STAMP_ADDR);

   AST_RESET_CLEAR: assert property (@(posedge clk_i)
      !rst_ni |=> (stamp_q == '0 && !rd_valid_o && !fault_o)); // R1

   AST_CORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_tick_i && !rate_const_i && !deep_sleep_i && !wr_at)
      |=> stamp_q == $past(stamp_q) + 1'b1); // R2

   AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deep_sleep_i && !wr_at) |=> $stable(stamp_q)); // R3

   AST_DENY_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stamp_rd_i && tsd_i && priv_i != '0) |=> fault_o); // R6

   AST_FAULT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> $past(stamp_rd_i)); // R6

   AST_REG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_at |=> rd_valid_o); // R7

   AST_LOW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_at && !wr_full_i) |=>
      (stamp_q[CNT_W-1:LOW_W] == '0 &&
       stamp_q[LOW_W-1:0] == $past(reg_wdata_i[LOW_W-1:0]))); // R8

   AST_WIDE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_at && wr_full_i) |=> stamp_q == $past(reg_wdata_i)); // R9

   AST_READ_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o |-> rd_data_o == $past(stamp_q)); // R12
endmodule

bind tsc_unit tsc_unit_chk #(
   .CNT_W      (CNT_W),
   .LOW_W      (LOW_W),
   .ADDR_W     (ADDR_W),
   .PRIV_W     (PRIV_W),
   .STAMP_ADDR (STAMP_ADDR)
) i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .core_tick_i  (core_tick_i),
   .rate_const_i (rate_const_i),
   .deep_sleep_i (deep_sleep_i),
   .stamp_rd_i   (stamp_rd_i),
   .reg_rd_i     (reg_rd_i),
   .reg_wr_i     (reg_wr_i),
   .reg_addr_i   (reg_addr_i),
   .reg_wdata_i  (reg_wdata_i),
   .wr_full_i    (wr_full_i),
   .priv_i       (priv_i),
   .tsd_i        (tsd_i),
   .rd_data_o    (rd_data_o),
   .rd_valid_o   (rd_valid_o),
   .fault_o      (fault_o),
   .stamp_q      (stamp_q)
);

// File: tb/test_tsc_unit.sv
`timescale 1ns/1ps
module test_tsc_unit;
   localparam int unsigned CNT_W  = 64;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned PRIV_W = 2;
   localparam logic [ADDR_W-1:0] A_STAMP = 12'h010;

   logic              clk = 1'b0;
   logic              rst_ni;
   logic              core_tick_i, ref_tick_i, rate_const_i, deep_sleep_i;
   logic              stamp_rd_i, reg_rd_i, reg_wr_i, wr_full_i, tsd_i;
   logic [ADDR_W-1:0] reg_addr_i;
   logic [CNT_W-1:0]  reg_wdata_i;
   logic [PRIV_W-1:0] priv_i;
   logic [CNT_W-1:0]  rd_data_o;
   logic              rd_valid_o, fault_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [CNT_W-1:0] exp_cnt;

   always #10 clk = ~clk;

   tsc_unit #(
      .CNT_W   (CNT_W),
      .LOW_W   (32),
      .ADDR_W  (ADDR_W),
      .PRIV_W  (PRIV_W),
      .REF_DIV (3)
   ) i_tsc_unit (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .core_tick_i  (core_tick_i),
      .ref_tick_i   (ref_tick_i),
      .rate_const_i (rate_const_i),
      .deep_sleep_i (deep_sleep_i),
      .stamp_rd_i   (stamp_rd_i),
      .reg_rd_i     (reg_rd_i),
      .reg_wr_i     (reg_wr_i),
      .reg_addr_i   (reg_addr_i),
      .reg_wdata_i  (reg_wdata_i),
      .wr_full_i    (wr_full_i),
      .priv_i       (priv_i),
      .tsd_i        (tsd_i),
      .rd_data_o    (rd_data_o),
      .rd_valid_o   (rd_valid_o),
      .fault_o      (fault_o)
   );

   task automatic check(input string req, input logic [CNT_W-1:0] got,
                        input logic [CNT_W-1:0] want);
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, got, want);
      end
   endtask

   task automatic tick_core(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) core_tick_i = 1'b1;
         @(negedge clk) core_tick_i = 1'b0;
      end
   endtask

   task automatic tick_ref(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ref_tick_i = 1'b1;
         @(negedge clk) ref_tick_i = 1'b0;
      end
   endtask

   task automatic reg_read(input logic [ADDR_W-1:0] a,
                           output logic [CNT_W-1:0] d, output logic v);
      @(negedge clk);
      reg_addr_i = a;
      reg_rd_i   = 1'b1;
      @(negedge clk);
      reg_rd_i = 1'b0;
      d = rd_data_o;
      v = rd_valid_o;
   endtask

   task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d,
                            input logic wide, input logic with_tick);
      @(negedge clk);
      reg_addr_i  = a;
      reg_wdata_i = d;
      wr_full_i   = wide;
      reg_wr_i    = 1'b1;
      core_tick_i = with_tick;
      @(negedge clk);
      reg_wr_i    = 1'b0;
      core_tick_i = 1'b0;
   endtask

   task automatic stamp_read(input logic [PRIV_W-1:0] p, input logic t,
                             output logic [CNT_W-1:0] d, output logic v,
                             output logic f);
      @(negedge clk);
      priv_i     = p;
      tsd_i      = t;
      stamp_rd_i = 1'b1;
      @(negedge clk);
      stamp_rd_i = 1'b0;
      d = rd_data_o;
      v = rd_valid_o;
      f = fault_o;
   endtask

   task automatic t_reset();
      logic [CNT_W-1:0] d; logic v;
      check("R1 valid in reset", 64'(rd_valid_o), 64'd0);
      check("R1 fault in reset", 64'(fault_o), 64'd0);
      @(negedge clk) rst_ni = 1'b1;
      reg_read(A_STAMP, d, v);
      check("R1 count after reset", d, 64'd0);
      exp_cnt = '0;
   endtask

   task automatic t_variable();
      logic [CNT_W-1:0] d; logic v;
      rate_const_i = 1'b0;
      tick_core(5);
      tick_ref(4);
      exp_cnt += 5;
      reg_read(A_STAMP, d, v);
      check("R2 core ticks counted, ref ignored", d, exp_cnt);
   endtask

   task automatic t_sleep();
      logic [CNT_W-1:0] d; logic v;
      deep_sleep_i = 1'b1;
      tick_core(6);
      reg_read(A_STAMP, d, v);
      check("R3 frozen in deep sleep", d, exp_cnt);
      reg_write(A_STAMP, 64'h0000_0000_0000_0100, 1'b1, 1'b0);
      exp_cnt = 64'h100;
      reg_read(A_STAMP, d, v);
      check("R3 write during sleep", d, exp_cnt);
      rate_const_i = 1'b1;
      tick_ref(4);
      deep_sleep_i = 1'b0;
      reg_read(A_STAMP, d, v);
      check("R3 ref ticks frozen in sleep", d, exp_cnt);
   endtask

   task automatic t_constant();
      logic [CNT_W-1:0] d; logic v;
      rate_const_i = 1'b1;
      tick_ref(7);
      tick_core(5);
      exp_cnt += 2;
      reg_read(A_STAMP, d, v);
      check("R4 seven ref ticks give two steps", d, exp_cnt);
      tick_ref(2);
      exp_cnt += 1;
      reg_read(A_STAMP, d, v);
      check("R4 prescaler phase carried", d, exp_cnt);
      rate_const_i = 1'b0;
   endtask

   task automatic t_privilege();
      logic [CNT_W-1:0] d; logic v, f;
      stamp_read(2'd3, 1'b0, d, v, f);
      check("R5 open read valid", 64'(v), 64'd1);
      check("R5 open read data", d, exp_cnt);
      stamp_read(2'd0, 1'b1, d, v, f);
      check("R5 level 0 restricted read", d, exp_cnt);
      stamp_read(2'd3, 1'b1, d, v, f);
      check("R6 fault raised", 64'(f), 64'd1);
      check("R6 no valid", 64'(v), 64'd0);
      check("R6 no data", d, 64'd0);
      @(negedge clk);
      check("R6 fault one cycle", 64'(fault_o), 64'd0);
      reg_read(A_STAMP, d, v);
      check("R7 register read ignores gate", d, exp_cnt);
      tsd_i = 1'b0; priv_i = '0;
   endtask

   task automatic t_address();
      logic [CNT_W-1:0] d; logic v;
      reg_read(12'h011, d, v);
      check("R7 other address no valid", 64'(v), 64'd0);
      reg_write(12'h020, 64'hFFFF, 1'b1, 1'b0);
      reg_read(A_STAMP, d, v);
      check("R7 other address write ignored", d, exp_cnt);
   endtask

   task automatic t_writes();
      logic [CNT_W-1:0] d; logic v;
      reg_write(A_STAMP, 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0);
      reg_read(A_STAMP, d, v);
      check("R8 low write clears high", d, 64'h0000_0000_1234_5678);
      reg_write(A_STAMP, 64'hDEAD_BEEF_1234_5678, 1'b1, 1'b0);
      reg_read(A_STAMP, d, v);
      check("R9 full write", d, 64'hDEAD_BEEF_1234_5678);
   endtask

   task automatic t_collide();
      logic [CNT_W-1:0] d; logic v;
      reg_write(A_STAMP, 64'h0000_0042_0000_0000, 1'b1, 1'b1);
      reg_read(A_STAMP, d, v);
      check("R10 write beats tick", d, 64'h0000_0042_0000_0000);
      tick_core(1);
      reg_read(A_STAMP, d, v);
      check("R10 counting resumes", d, 64'h0000_0042_0000_0001);
   endtask

   task automatic t_wrap();
      logic [CNT_W-1:0] d; logic v;
      reg_write(A_STAMP, '1, 1'b1, 1'b0);
      tick_core(1);
      reg_read(A_STAMP, d, v);
      check("R11 wrap to zero", d, 64'd0);
   endtask

   task automatic t_read_inc();
      logic [CNT_W-1:0] d; logic v;
      reg_write(A_STAMP, 64'h77, 1'b1, 1'b0);
      @(negedge clk);
      priv_i = '0;
      tsd_i = 1'b0;
      stamp_rd_i = 1'b1;
      core_tick_i = 1'b1;
      @(negedge clk);
      stamp_rd_i = 1'b0;
      core_tick_i = 1'b0;
      check("R12 read returns pre-increment", rd_data_o, 64'h77);
      reg_read(A_STAMP, d, v);
      check("R12 increment applied", d, 64'h78);
   endtask

   initial begin
      rst_ni = 1'b0;
      core_tick_i = 0; ref_tick_i = 0; rate_const_i = 0; deep_sleep_i = 0;
      stamp_rd_i = 0; reg_rd_i = 0; reg_wr_i = 0; wr_full_i = 0; tsd_i = 0;
      reg_addr_i = '0; reg_wdata_i = '0; priv_i = '0;
      repeat (3) @(negedge clk);
      t_reset();
      t_variable();
      t_sleep();
      t_constant();
      t_privilege();
      t_address();
      t_writes();
      t_collide();
      t_wrap();
      t_read_inc();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule